// File: doc/BRIEF.md
# Pipelined Bit-Serial-Stage Ripple Adder

This block adds two unsigned operands with a carry-ripple chain that is cut into pipeline stages. Each stage holds a single one-bit full adder. The carry produced by bit i is registered before bit i+1 uses it. Operand bits are skewed on entry by delay registers, so that bit i reaches its stage in the same cycle as the carry from bit i-1. Sum bits are then deskewed by further delay registers, so that the whole result, sum and carry-out together, leaves the block in one cycle.

The critical path is one full adder plus a flip-flop. In return there is a fixed latency equal to the operand width. A new operand pair can enter on every clock. A valid flag travels beside the data to mark which output cycles carry results.

Top module: `rpa_adder`

## Requirements
- R1: When valid_o is high, sum_o equals the low W bits of a_i + b_i, where a_i and b_i are the operands presented with valid_i high W cycles earlier (W = 4 by default).
- R2: When valid_o is high, carry_o equals bit W of that same unsigned sum.
- R3: valid_o is high in a cycle exactly when valid_i was high W clock edges before.
- R4: Operand pairs presented with valid_i on consecutive cycles each produce their own correct result on consecutive output cycles, with no bubble and no mixing of carries between additions.
- R5: While rst_ni is low, valid_o is low. After rst_ni is released, valid_o stays low until an operand pair accepted after the release has travelled through the pipeline.
- R6: Cycles with valid_i low give valid_o low W cycles later, and they do not disturb the results of valid additions on either side of them.
- R7: The carry into bit 0 is zero: the operand pair 0 + 0 gives sum_o = 0 and carry_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every pipeline register uses its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the valid pipeline |
| valid_i | input | 1 | Marks a_i and b_i as an operand pair to add |
| a_i | input | W | First unsigned operand |
| b_i | input | W | Second unsigned operand |
| valid_o | output | 1 | Marks sum_o and carry_o as a result |
| sum_o | output | W | Low W bits of the sum |
| carry_o | output | 1 | Carry out of the most significant bit |

## Verification
All 256 operand pairs are sent back to back. This covers every carry chain length, from no carry at all to a carry rippling through all four stages (for example 15 + 1). It also shows whether adjacent additions leak carries into each other. A second sweep adds idle gaps between valid pairs, which separates the valid flag timing from the data path. A reset in the middle of a stream shows whether results that were in flight are dropped. Zero plus zero is checked on its own to confirm that the carry into bit 0 is zero.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
  typedef struct packed {
    logic sum;
    logic cout;
  } fa_res_t;

  function automatic fa_res_t full_add(input logic x, input logic y, input logic cin);
    fa_res_t r;
    r.sum  = x ^ y ^ cin;
    r.cout = (x & y) | (cin & (x ^ y));
    return r;
  endfunction
endpackage

// File: rtl/rpa_delay.sv
module rpa_delay #(
  parameter int unsigned DW    = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic          clk_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  if (DEPTH == 0) begin : g_pass
    assign q_o = d_i;
  end else begin : g_regs
    logic [DW-1:0] tap_q [DEPTH];
    always_ff @(posedge clk_i) begin
      tap_q[0] <= d_i;
      for (int k = 1; k < DEPTH; k++) tap_q[k] <= tap_q[k-1];
    end
    assign q_o = tap_q[DEPTH-1];
  end
endmodule

// File: rtl/rpa_stage.sv
module rpa_stage
  import rpa_pkg::*;
(
  input  logic clk_i,
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o
);
  fa_res_t res_d;

  assign res_d = full_add(a_i, b_i, cin_i);

  always_ff @(posedge clk_i) begin
    sum_o  <= res_d.sum;
    cout_o <= res_d.cout;
  end
endmodule

// File: rtl/rpa_adder.sv
module rpa_adder #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  localparam int unsigned LAT = W;

  logic [W:0]   carry_q;
  logic [W-1:0] a_skew, b_skew, sum_stage;
  logic [LAT-1:0] vld_q;

  assign carry_q[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] op_skew;

    // bit i waits i cycles to meet carry from stage i-1
    rpa_delay #(.DW(2), .DEPTH(i)) u_skew (
      .clk_i (clk_i),
      .d_i   ({a_i[i], b_i[i]}),
      .q_o   (op_skew)
    );
    assign a_skew[i] = op_skew[1];
    assign b_skew[i] = op_skew[0];

    rpa_stage u_stage (
      .clk_i  (clk_i),
      .a_i    (a_skew[i]),
      .b_i    (b_skew[i]),
      .cin_i  (carry_q[i]),
      .sum_o  (sum_stage[i]),
      .cout_o (carry_q[i+1])
    );

    rpa_delay #(.DW(1), .DEPTH(W-1-i)) u_deskew (
      .clk_i (clk_i),
      .d_i   (sum_stage[i]),
      .q_o   (sum_o[i])
    );
  end

  assign carry_o = carry_q[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], valid_i};
  end

  assign valid_o = vld_q[LAT-1];
endmodule

// File: rtl/rpa_adder_chk.sv
module rpa_adder_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         valid_o,
  input logic [W-1:0] sum_o,
  input logic         carry_o
);
  logic [W-1:0] a_h [W];
  logic [W-1:0] b_h [W];
  logic [W-1:0] v_h;
  logic [W:0]   ref_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_h <= '0;
    else         v_h <= {v_h[W-2:0], valid_i};
  end

  always_ff @(posedge clk_i) begin
    a_h[0] <= a_i;
    b_h[0] <= b_i;
    for (int k = 1; k < W; k++) begin
      a_h[k] <= a_h[k-1];
      b_h[k] <= b_h[k-1];
    end
  end

  assign ref_sum = {1'b0, a_h[W-1]} + {1'b0, b_h[W-1]};

  a_r1_sum_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sum_o == ref_sum[W-1:0]);

  a_r2_carry_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> carry_o == ref_sum[W]);

  a_r3_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_h[W-1]);

  a_r5_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o);

  a_r7_zero_cin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && a_h[W-1] == '0 && b_h[W-1] == '0) |-> (sum_o == '0 && !carry_o));
endmodule

bind rpa_adder rpa_adder_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .valid_o (valid_o),
  .sum_o   (sum_o),
  .carry_o (carry_o)
);

// File: tb/rpa_adder_bench.sv
module rpa_adder_bench;
  localparam int W      = 4;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         valid_o;
  logic [W-1:0] sum_o;
  logic         carry_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // history of applied stimulus, index 0 = most recent
  logic         h_v [W];
  logic [W-1:0] h_a [W];
  logic [W-1:0] h_b [W];
  logic         prev_exp_v = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  rpa_adder #(.W(W)) u_rpa_adder (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (valid_o),
    .sum_o   (sum_o),
    .carry_o (carry_o)
  );

  task automatic clear_hist();
    for (int k = 0; k < W; k++) begin
      h_v[k] = 1'b0; h_a[k] = '0; h_b[k] = '0;
    end
    prev_exp_v = 1'b0;
  endtask

  // called at a negedge: check output of stimulus W edges ago, then apply new stimulus
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] exp_s;
    string vreq;
    exp_s = {1'b0, h_a[W-1]} + {1'b0, h_b[W-1]};
    vreq = h_v[W-1] ? (prev_exp_v ? "R4" : "R3") : "R6";
    checks++;
    if (valid_o !== h_v[W-1]) begin
      errors++;
      $display("FAIL %s valid_o actual=%b expected=%b", vreq, valid_o, h_v[W-1]);
    end
    if (h_v[W-1]) begin
      string sreq;
      sreq = (h_a[W-1] == 0 && h_b[W-1] == 0) ? "R7" : "R1";
      checks++;
      if (sum_o !== exp_s[W-1:0]) begin
        errors++;
        $display("FAIL %s sum_o for %0d+%0d actual=%0d expected=%0d",
                 sreq, h_a[W-1], h_b[W-1], sum_o, exp_s[W-1:0]);
      end
      checks++;
      if (carry_o !== exp_s[W]) begin
        errors++;
        $display("FAIL R2 carry_o for %0d+%0d actual=%b expected=%b",
                 h_a[W-1], h_b[W-1], carry_o, exp_s[W]);
      end
    end
    prev_exp_v = h_v[W-1];
    for (int k = W-1; k > 0; k--) begin
      h_v[k] = h_v[k-1]; h_a[k] = h_a[k-1]; h_b[k] = h_b[k-1];
    end
    h_v[0] = v; h_a[0] = a; h_b[0] = b;
    valid_i = v; a_i = a; b_i = b;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clear_hist();
    repeat (3) @(negedge clk);
    checks++; // R5 reset state
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R5 valid_o in reset actual=%b expected=0", valid_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R7: all pairs back to back
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        step(1'b1, W'(a), W'(b));
    for (int k = 0; k < W + 1; k++) step(1'b0, 4'hF, 4'hF);

    // R6: idle gaps with garbage operands between valid pairs
    for (int a = 0; a < 16; a++)
      for (int b = 15; b >= 0; b -= 3) begin
        step(1'b1, W'(a), W'(b));
        step(1'b0, ~W'(a), W'(b + 1));
        if (b % 2 == 0) step(1'b0, 4'hF, 4'h1);
      end
    for (int k = 0; k < W + 1; k++) step(1'b0, '0, '0);

    // R5: reset while results are in flight
    for (int k = 0; k < 2; k++) step(1'b1, 4'd15, 4'd1);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    clear_hist();
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R5 valid_o during reset actual=%b expected=0", valid_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < W + 2; k++) begin
      checks++;
      if (valid_o !== 1'b0) begin
        errors++;
        $display("FAIL R5 valid_o after reset actual=%b expected=0", valid_o);
      end
      @(negedge clk);
    end

    // R7: isolated zero pair after reset
    step(1'b1, '0, '0);
    for (int k = 0; k < W + 1; k++) step(1'b0, 4'hA, 4'h5);

    finish_run();
  end
endmodule